// File: doc/BRIEF.md
# Color-Fill Video Memory Array Controller

This block is the storage core of a small video memory. Each row holds 512 words of 8 bits. The block takes decoded commands, one per clock, together with a row address, a column address, an 8-bit data bus and an 8-bit I/O mask. It performs three kinds of update. A plain word write takes its value from the data bus. A block fill writes the color register into any subset of an aligned group of four columns. A row fill writes the color register into every column of one row. Every update goes through the I/O mask, one bit per I/O line.

The color register is loaded from the data bus by its own command. During a block fill the data bus does not carry pixel data. Its low four bits instead say which columns of the group are written. The column enables and the I/O mask act independently, so a single block fill can change up to 32 bits. A row fill runs as a sweep of one four-column group per clock. While the sweep runs the block reports busy and ignores every new command. Reads return one word in the clock after the request.

Top module: `vram_fill_ctrl`

## Requirements
- R1: After reset, `busy` and `rd_valid` are low and the color register holds 0.
- R2: A READ command (code 2) accepted while not busy gives `rd_valid` high in the next clock, with `rd_data` holding the addressed word. No other command and no busy clock produces `rd_valid`.
- R3: A WRITE command (code 1) changes stored bit i of the addressed word to `data_in[i]` only where `io_mask[i]` is 1. Bits with a 0 mask bit keep their value.
- R4: A LOAD_COLOR command (code 3) copies `data_in` into the color register. The color register changes on no other command and never while busy. `io_mask` does not affect the load.
- R5: A FLASH command (code 4) sets bit i of every column in the addressed row to color bit i wherever `io_mask[i]` is 1. All other rows, and all unmasked bits, keep their values.
- R6: Once a FLASH command is accepted, `busy` goes high in the next clock and stays high for exactly COLS/BLK = 128 clocks. Commands given while busy (codes 1 to 5) have no effect.
- R7: A BLOCK command (code 5) addresses the group that starts at the column address with its two low bits cleared. `data_in[k]` = 1 enables column offset k (k = 0..3) of that group. Each enabled column gets the color written under the I/O mask rule of R3.
- R8: A BLOCK command leaves columns outside the addressed group, and all other rows, unchanged.
- R9: BLOCK commands in consecutive clocks (page mode) all take effect. A READ followed in the next clock by a BLOCK to the same word returns the value from before the fill (read-modify-write order).
- R10: Code 0 (NOP), and codes 6 and 7, change no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 3 | Command code: 0 NOP, 1 WRITE, 2 READ, 3 LOAD_COLOR, 4 FLASH, 5 BLOCK |
| row_addr | input | 2 | Row address (log2 ROWS) |
| col_addr | input | 9 | Column address (log2 COLS) |
| data_in | input | 8 | Write data, color value, or column enables in bits 3:0 during BLOCK |
| io_mask | input | 8 | Per-I/O-line write enable, 1 = write |
| rd_data | output | 8 | Word returned by READ |
| rd_valid | output | 1 | High in the clock after an accepted READ |
| busy | output | 1 | Row-fill sweep in progress; commands ignored |

## Verification
A corrupt color register shows up as wrong data in every later fill. One full-row readback after a fill therefore exposes it. A sweep counter that skips groups, or wraps early, leaves stale words at fixed column positions in the filled row. It also changes the length of `busy`, which is measured in the first clock after the sweep. Faulty lane or mask steering shows up as stray bits or missing bits in neighbouring columns or rows. Every test pattern ends with a compare of the whole array against a model, so such damage is caught even when it lands far from the word that was addressed.

// File: rtl/vfc_pkg.sv
// Package: command codes shared by the fill controller, its checker and bench.
package vfc_pkg;
    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_WRITE = 3'd1,
        CMD_READ  = 3'd2,
        CMD_LOAD  = 3'd3,
        CMD_FLASH = 3'd4,
        CMD_BLOCK = 3'd5
    } cmd_e;
endpackage

// File: rtl/vfc_color_reg.sv
// Module: vfc_color_reg
// Holds the fill color. Loads when 'load' is high.
// Assumes the caller gates 'load' with the not-busy condition.
module vfc_color_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] color
);
    // Color storage: cleared on reset, replaced on load.
    always_ff @(posedge clk) begin
        if (!rst_n)    color <= '0;
        else if (load) color <= din;
    end
endmodule

// File: rtl/vfc_flash_seq.sv
// Module: vfc_flash_seq
// Row-fill sequencer. On 'start' it latches the row and the I/O mask.
// It then steps through every column group, one per clock, and drops 'busy'
// after the last one. Assumes 'start' is only raised while not busy.
module vfc_flash_seq #(
    parameter int ROW_W  = 2,
    parameter int GROUPS = 128,
    parameter int W      = 8,
    localparam int GRP_W = $clog2(GROUPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ROW_W-1:0] start_row,
    input  logic [W-1:0]     start_mask,
    output logic             busy,
    output logic [ROW_W-1:0] row,
    output logic [W-1:0]     mask,
    output logic [GRP_W-1:0] grp
);
    localparam logic [GRP_W-1:0] LAST = GRP_W'(GROUPS - 1);

    // Sweep state: latch the target on start, advance a group each busy clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            grp  <= '0;
            row  <= '0;
            mask <= '0;
        end else if (busy) begin
            if (grp == LAST) begin
                busy <= 1'b0;
                grp  <= '0;
            end else begin
                grp <= grp + 1'b1;
            end
        end else if (start) begin
            busy <= 1'b1;
            grp  <= '0;
            row  <= start_row;
            mask <= start_mask;
        end
    end
endmodule

// File: rtl/vfc_array.sv
// Module: vfc_array
// Storage organised as rows x groups x lanes of W-bit words.
// One write port updates any subset of the lanes of one group, bit-masked,
// with the same data word. One registered read port returns the old data
// when it hits a word being written in the same clock.
module vfc_array #(
    parameter int ROWS = 4,
    parameter int COLS = 512,
    parameter int BLK  = 4,
    parameter int W    = 8,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int COL_W  = $clog2(COLS),
    localparam int LANE_W = $clog2(BLK),
    localparam int GROUPS = COLS / BLK,
    localparam int GRP_W  = $clog2(GROUPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [GRP_W-1:0] wr_grp,
    input  logic [BLK-1:0]   wr_lanes,
    input  logic [W-1:0]     wr_bits,
    input  logic [W-1:0]     wr_data,
    input  logic             re,
    input  logic [ROW_W-1:0] rd_row,
    input  logic [COL_W-1:0] rd_col,
    output logic [W-1:0]     rd_data,
    output logic             rd_valid
);
    logic [W-1:0] mem [ROWS][GROUPS][BLK];

    // One write lane per word of a group; each merges the masked bits.
    for (genvar l = 0; l < BLK; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (we && wr_lanes[l])
                mem[wr_row][wr_grp][l] <= (mem[wr_row][wr_grp][l] & ~wr_bits)
                                        | (wr_data & wr_bits);
        end
    end

    // Read port: registered word and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= re;
            if (re)
                rd_data <= mem[rd_row][rd_col[COL_W-1:LANE_W]][rd_col[LANE_W-1:0]];
        end
    end
endmodule

// File: rtl/vram_fill_ctrl.sv
// Module: vram_fill_ctrl (top)
// Decodes one command per clock. It steers word writes, block fills and
// row-fill sweeps onto the single write port of the array. Assumes BLK <= W,
// since the column enables of a block fill travel on data_in[BLK-1:0].
module vram_fill_ctrl #(
    parameter int ROWS = 4,
    parameter int COLS = 512,
    parameter int BLK  = 4,
    parameter int W    = 8,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int COL_W  = $clog2(COLS),
    localparam int LANE_W = $clog2(BLK),
    localparam int GROUPS = COLS / BLK,
    localparam int GRP_W  = $clog2(GROUPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cmd,
    input  logic [ROW_W-1:0] row_addr,
    input  logic [COL_W-1:0] col_addr,
    input  logic [W-1:0]     data_in,
    input  logic [W-1:0]     io_mask,
    output logic [W-1:0]     rd_data,
    output logic             rd_valid,
    output logic             busy
);
    import vfc_pkg::*;

    logic [W-1:0]     color_q;
    logic [ROW_W-1:0] seq_row;
    logic [W-1:0]     seq_mask;
    logic [GRP_W-1:0] seq_grp;
    logic             idle;
    logic             we;
    logic [ROW_W-1:0] wr_row;
    logic [GRP_W-1:0] wr_grp;
    logic [BLK-1:0]   wr_lanes;
    logic [W-1:0]     wr_bits;
    logic [W-1:0]     wr_data;

    assign idle = !busy;

    vfc_color_reg #(.W(W)) u_color (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (idle && cmd == CMD_LOAD),
        .din   (data_in),
        .color (color_q)
    );

    vfc_flash_seq #(.ROW_W(ROW_W), .GROUPS(GROUPS), .W(W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (idle && cmd == CMD_FLASH),
        .start_row  (row_addr),
        .start_mask (io_mask),
        .busy       (busy),
        .row        (seq_row),
        .mask       (seq_mask),
        .grp        (seq_grp)
    );

    // Write-port steering: the sweep owns the port while busy, else the command.
    always_comb begin
        we       = 1'b0;
        wr_row   = row_addr;
        wr_grp   = col_addr[COL_W-1:LANE_W];
        wr_lanes = '0;
        wr_bits  = io_mask;
        wr_data  = color_q;
        if (busy) begin
            we       = 1'b1;
            wr_row   = seq_row;
            wr_grp   = seq_grp;
            wr_lanes = '1;
            wr_bits  = seq_mask;
        end else if (cmd == CMD_WRITE) begin
            we       = 1'b1;
            wr_lanes = BLK'(1) << col_addr[LANE_W-1:0];
            wr_data  = data_in;
        end else if (cmd == CMD_BLOCK) begin
            we       = 1'b1;
            wr_lanes = data_in[BLK-1:0];
        end
    end

    vfc_array #(.ROWS(ROWS), .COLS(COLS), .BLK(BLK), .W(W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (we),
        .wr_row   (wr_row),
        .wr_grp   (wr_grp),
        .wr_lanes (wr_lanes),
        .wr_bits  (wr_bits),
        .wr_data  (wr_data),
        .re       (idle && cmd == CMD_READ),
        .rd_row   (row_addr),
        .rd_col   (col_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/vram_fill_ctrl_chk.sv
// Module: vram_fill_ctrl_chk
// Protocol checker bound to the top. Covers read timing, sweep length,
// sweep start cause and color register stability.
module vram_fill_ctrl_chk #(
    parameter int GROUPS = 128,
    parameter int W      = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   cmd,
    input logic         busy,
    input logic         rd_valid,
    input logic [W-1:0] color
);
    import vfc_pkg::*;

    int run_len;

    // Length of the current busy run, in clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    // R2
    read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_READ && !busy) |=> rd_valid);

    // R2
    no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd == CMD_READ && !busy) |=> !rd_valid);

    // R6
    sweep_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_len == GROUPS);

    // R6
    sweep_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd) == CMD_FLASH);

    // R4
    color_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_LOAD || busy) |=> $stable(color));
endmodule

bind vram_fill_ctrl vram_fill_ctrl_chk #(.GROUPS(GROUPS), .W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .busy     (busy),
    .rd_valid (rd_valid),
    .color    (color_q)
);

// File: tb/vram_fill_ctrl_test.sv
// Bench for vram_fill_ctrl. It keeps a word-level model of the whole array,
// drives command patterns, and compares reads against the model.
module vram_fill_ctrl_test;
    import vfc_pkg::*;

    localparam int PERIOD = 10;
    localparam int ROWS   = 4;
    localparam int COLS   = 512;
    localparam int BLK    = 4;
    localparam int GROUPS = COLS / BLK;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd = CMD_NOP;
    logic [1:0] row_addr = '0;
    logic [8:0] col_addr = '0;
    logic [7:0] data_in = '0;
    logic [7:0] io_mask = '0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       busy;

    logic [7:0] model [ROWS][COLS];
    logic [7:0] mcolor = '0;
    int checks = 0;
    int failures = 0;

    always #(PERIOD/2) clk = ~clk;

    vram_fill_ctrl uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .row_addr (row_addr),
        .col_addr (col_addr),
        .data_in  (data_in),
        .io_mask  (io_mask),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .busy     (busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] merge(input logic [7:0] old, input logic [7:0] d,
                                         input logic [7:0] m);
        return (old & ~m) | (d & m);
    endfunction

    // Issue one command for one clock, then return the bus to NOP.
    task automatic issue(input logic [2:0] c, input int r, input int col,
                         input logic [7:0] d, input logic [7:0] m);
        cmd = c; row_addr = 2'(r); col_addr = 9'(col); data_in = d; io_mask = m;
        @(negedge clk);
        cmd = CMD_NOP;
    endtask

    task automatic read_chk(input int r, input int col, input string req);
        cmd = CMD_READ; row_addr = 2'(r); col_addr = 9'(col);
        @(negedge clk);
        cmd = CMD_NOP;
        check(rd_valid === 1'b1, req, int'(rd_valid), 1);
        check(rd_data === model[r][col], req, int'(rd_data), int'(model[r][col]));
    endtask

    task automatic load_color(input logic [7:0] c);
        issue(CMD_LOAD, 0, 0, c, 8'h00);
        mcolor = c;
    endtask

    task automatic block_fill(input int r, input int col, input logic [3:0] en,
                              input logic [7:0] m);
        issue(CMD_BLOCK, r, col, {4'h0, en}, m);
        for (int k = 0; k < BLK; k++)
            if (en[k]) model[r][(col & ~3) + k] = merge(model[r][(col & ~3) + k], mcolor, m);
    endtask

    // Row fill; measures the busy run. With poke set, it also tries commands
    // while busy and checks that they are ignored.
    task automatic flash(input int r, input logic [7:0] m, input bit poke);
        int n;
        issue(CMD_FLASH, r, 0, 8'h00, m);
        n = 0;
        while (busy === 1'b1 && n < 1000) begin
            n++;
            if (poke && n == 5) begin
                cmd = CMD_WRITE; row_addr = 2'd3; col_addr = 9'd7; data_in = 8'hFF; io_mask = 8'hFF;
            end else if (poke && n == 6) begin
                cmd = CMD_LOAD; data_in = 8'h77;
            end else if (poke && n == 7) begin
                cmd = CMD_READ; row_addr = 2'd0; col_addr = 9'd0;
            end else if (poke && n == 8) begin
                cmd = CMD_BLOCK; row_addr = 2'd3; col_addr = 9'd20; data_in = 8'h0F; io_mask = 8'hFF;
            end else begin
                cmd = CMD_NOP;
            end
            if (poke && n == 8) check(rd_valid === 1'b0, "R6 read while busy", int'(rd_valid), 0);
            @(negedge clk);
        end
        cmd = CMD_NOP;
        // R6: exact sweep length
        check(n == GROUPS, "R6 busy length", n, GROUPS);
        for (int c = 0; c < COLS; c++) model[r][c] = merge(model[r][c], mcolor, m);
    endtask

    task automatic compare_all(input string req);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                read_chk(r, c, req);
    endtask

    initial begin
        #(PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        check(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
        check(rd_valid === 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);

        // R1/R5: a fill with the reset color clears every row
        for (int r = 0; r < ROWS; r++) flash(r, 8'hFF, 1'b0);
        compare_all("R1 R5 clear by reset color");

        // R4, R5: masked fill of row 1; io_mask ignored on load
        issue(CMD_LOAD, 0, 0, 8'hA5, 8'h00);
        mcolor = 8'hA5;
        flash(1, 8'h0F, 1'b0);
        for (int c = 0; c < COLS; c++) read_chk(1, c, "R5 masked row fill");
        read_chk(0, 511, "R5 other row untouched");

        // R6: commands while busy are ignored (row 2 fill)
        load_color(8'h3C);
        flash(2, 8'hF0, 1'b1);
        read_chk(3, 7, "R6 write while busy ignored");
        read_chk(3, 20, "R6 block while busy ignored");
        block_fill(0, 40, 4'h1, 8'hFF);
        read_chk(0, 40, "R4 color unchanged by load while busy");

        // R3: exhaustive mask sweep on one word
        for (int m = 0; m < 256; m++) begin
            issue(CMD_WRITE, 3, 100, 8'(m) ^ 8'h5A, 8'(m));
            model[3][100] = merge(model[3][100], 8'(m) ^ 8'h5A, 8'(m));
            read_chk(3, 100, "R3 masked write");
        end
        issue(CMD_WRITE, 3, 101, 8'hC3, 8'hFF);
        model[3][101] = 8'hC3;
        read_chk(3, 101, "R3 full write");

        // R10: idle and unused codes change nothing
        issue(3'd0, 3, 101, 8'hFF, 8'hFF);
        issue(3'd6, 3, 101, 8'h00, 8'hFF);
        issue(3'd7, 3, 101, 8'h00, 8'hFF);
        read_chk(3, 101, "R10 unused codes");

        // R7, R8: all column enables x all low address bits, each in its own group
        for (int en = 0; en < 16; en++)
            for (int lsb = 0; lsb < 4; lsb++) begin
                int col;
                col = (en + 16 * lsb) * 4 + lsb;
                load_color(8'(en * 13 + lsb * 64 + 1));
                block_fill(2, col, 4'(en), 8'hFF ^ 8'(en * 17));
                for (int k = -1; k < 5; k++)
                    if ((col & ~3) + k >= 0) read_chk(2, (col & ~3) + k, "R7 R8 block fill");
            end

        // R9: page-mode block fills on consecutive clocks, then read-modify-write
        load_color(8'h96);
        cmd = CMD_BLOCK; row_addr = 2'd0; col_addr = 9'd8;  data_in = 8'h0F; io_mask = 8'hFF;
        @(negedge clk);
        col_addr = 9'd13; data_in = 8'h0F; io_mask = 8'h3C;
        @(negedge clk);
        col_addr = 9'd18; data_in = 8'h05; io_mask = 8'hFF;
        @(negedge clk);
        cmd = CMD_NOP;
        for (int k = 0; k < 4; k++) model[0][8 + k] = 8'h96;
        for (int k = 0; k < 4; k++) model[0][12 + k] = merge(model[0][12 + k], 8'h96, 8'h3C);
        model[0][16] = 8'h96;
        model[0][18] = 8'h96;
        for (int c = 4; c < 24; c++) read_chk(0, c, "R9 page mode fills");

        load_color(8'h0F);
        cmd = CMD_READ; row_addr = 2'd0; col_addr = 9'd9;
        @(negedge clk);
        cmd = CMD_BLOCK; data_in = 8'h02; io_mask = 8'hF0;
        check(rd_data === model[0][9], "R9 read before fill", int'(rd_data), int'(model[0][9]));
        @(negedge clk);
        cmd = CMD_NOP;
        model[0][9] = merge(model[0][9], 8'h0F, 8'hF0);
        read_chk(0, 9, "R9 fill after read");

        compare_all("R8 final array");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule